// File: doc/BRIEF.md
# Serial-Port Bit-Clock and Frame-Sync Generator

This block creates the bit clock and the frame-sync pulse for a synchronous serial port. It works entirely in the core clock domain. The bit clock is a registered level whose period is a programmable number of core clocks. The frame sync is a pulse that repeats every programmable number of bit-clock periods and has a programmable width. Both are exported raw. Gated copies are exported per direction, receive and transmit.

Four enables control the block: the generator enable, the frame enable, the receive enable and the transmit enable. A direction whose enable is low keeps its frame-sync pin at the inactive level that its polarity input selects, while the other direction keeps running from the same shared pulse. The transmit enable also drives the output enable of the transmit data pin.

After device reset the generator runs a fixed divide-by-two clock until software first raises the generator enable. Once the generator enable has been raised, lowering it stops the clock. Divider, frame period and frame width are captured only while the generator enable is low, so a running clock never changes shape.

Top module: `srg_core`

## Requirements
- R1: While the device reset is active and afterwards until `gen_en` is first sampled high, `bclk` alternates high and low every core clock (period 2), starting high. During this time `fsync`, `rx_sck` and `tx_sck` stay low, and `div_val` is ignored.
- R2: After `gen_en` has been sampled high once, a later `gen_en` low holds `bclk` low from the next core cycle and `fsync` low from the cycle after that.
- R3: While the generator runs, `bclk` has a period of P = max(`div_val`,1)+1 core clocks. It is high for the first floor(P/2) cycles of each period. The first period starts in the cycle after `gen_en` is first sampled high from a stopped state. A value of 0 gives the same clock as a value of 1.
- R4: `div_val`, `frm_per` and `frm_wid` are captured only on core edges where `gen_en` is low. Changes made while it is high have no effect on `bclk` or `fsync`.
- R5: Once `gen_en` and `fs_en` are both high, `fsync` stays low through eight complete `bclk` periods. It rises at the start of the ninth period, together with a rising `bclk`. When both enables rise together from a stopped generator, this happens 1+8P core edges after they are first sampled.
- R6: After its first rise, `fsync` repeats every `frm_per`+1 `bclk` periods and is high for `frm_wid`+1 periods of each frame. It stays high without a break when `frm_wid` ≥ `frm_per`.
- R7: `fs_en` sampled low forces `fsync` low in the next cycle. Raising it again restarts the eight-period wait.
- R8: `rx_fs` equals `rx_fs_pol` XOR (`fsync` AND `rx_en`), and `tx_fs` equals `tx_fs_pol` XOR (`fsync` AND `tx_en`). A polarity of 0 means active high, and the inactive level equals the polarity bit.
- R9: `tx_data_oe` is 1 exactly when `tx_en` is 1. When it is 0 the transmit pin floats.
- R10: `rx_sck` and `tx_sck` equal `bclk` only when `gen_en` was sampled high at the previous edge (the reset-time clock is excluded). Otherwise they are low.
- R11: One direction held in reset does not change the frame sync or clock seen by the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| gen_en | input | 1 | Generator enable (0 = held in reset) |
| fs_en | input | 1 | Frame-sync logic enable |
| rx_en | input | 1 | Receive direction enable |
| tx_en | input | 1 | Transmit direction enable |
| div_val | input | DIV_W | Clock divider value |
| frm_per | input | PER_W | Frame period minus one, in bit clocks |
| frm_wid | input | WID_W | Frame-sync width minus one, in bit clocks |
| rx_fs_pol | input | 1 | Receive frame-sync polarity (1 = active low) |
| tx_fs_pol | input | 1 | Transmit frame-sync polarity (1 = active low) |
| bclk | output | 1 | Raw generated bit clock |
| fsync | output | 1 | Raw generated frame sync, active high |
| rx_sck | output | 1 | Receive bit clock output |
| tx_sck | output | 1 | Transmit bit clock output |
| rx_fs | output | 1 | Receive frame-sync output |
| tx_fs | output | 1 | Transmit frame-sync output |
| tx_data_oe | output | 1 | Transmit data pin output enable |

## Verification
Two events meet in one cycle when the bench raises the generator and frame enables on the same edge: the bit clock restarts from phase zero, and the eight-period frame-sync wait begins counting. The rise of `fsync` is then judged against the closed-form count 1+8P, as well as against the cycle-by-cycle model. A second collision comes from dropping `rx_en` while frames are in flight. In the same cycles the bench checks that `tx_fs` keeps pulsing, and that the receive pin parks at its polarity level.

// File: rtl/srg_pkg.sv
package srg_pkg;

    // Frame-sync sequencer phase
    typedef enum logic {
        FR_ARM = 1'b0,   // waiting out the start-up bit-clock periods
        FR_RUN = 1'b1    // producing frames
    } fr_mode_t;

    // Pin-side gated outputs
    typedef struct packed {
        logic rx_sck;
        logic tx_sck;
        logic rx_fs;
        logic tx_fs;
        logic tx_oe;
    } pin_out_t;

endpackage

// File: rtl/srg_clkdiv.sv
module srg_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             bclk,
    output logic             tick,
    output logic             gen_act
);

    localparam int EXT_W = DIV_W + 1;

    typedef struct packed {
        logic             boot;
        logic             run;
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_q, st_d;
    logic [DIV_W-1:0] lim;
    logic [EXT_W-1:0] half;
    logic             wrap;

    always_comb begin
        // boot phase forces divide-by-two; zero divider is clamped to one
        if (st_q.boot || st_q.div == '0) begin
            lim = DIV_W'(1);
        end else begin
            lim = st_q.div;
        end
        half = (EXT_W'(lim) + EXT_W'(1)) >> 1;
        wrap = st_q.run && (st_q.cnt == lim);

        st_d      = st_q;
        st_d.boot = st_q.boot & ~gen_en;
        st_d.run  = gen_en | st_d.boot;
        if (st_d.run && st_q.run && !wrap) begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end else begin
            st_d.cnt = '0;
        end
        if (!gen_en) begin
            st_d.div = div_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{boot: 1'b1, run: 1'b1, div: '0, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk    = st_q.run && (EXT_W'(st_q.cnt) < half);
    assign tick    = wrap;
    assign gen_act = st_q.run & ~st_q.boot;

endmodule

// File: rtl/srg_frame.sv
module srg_frame
    import srg_pkg::*;
#(
    parameter int PER_W = 12,
    parameter int WID_W = 8,
    parameter int ARM_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             gen_act,
    input  logic             fs_en,
    input  logic             tick,
    input  logic [PER_W-1:0] frm_per,
    input  logic [WID_W-1:0] frm_wid,
    output logic             fsync
);

    localparam int ARM_W = $clog2(ARM_N + 1);
    localparam int CMP_W = (PER_W > WID_W) ? PER_W : WID_W;

    typedef struct packed {
        fr_mode_t         mode;
        logic [ARM_W-1:0] arm;
        logic [PER_W-1:0] per;
        logic [WID_W-1:0] wid;
        logic [PER_W-1:0] pos;
        logic             fs;
    } fr_state_t;

    fr_state_t        st_q, st_d;
    logic [PER_W-1:0] pos_nx;

    always_comb begin
        st_d   = st_q;
        pos_nx = (st_q.pos == st_q.per) ? '0 : st_q.pos + PER_W'(1);

        if (!(fs_en && gen_act)) begin
            st_d.mode = FR_ARM;
            st_d.arm  = '0;
            st_d.pos  = '0;
            st_d.fs   = 1'b0;
        end else if (tick) begin
            case (st_q.mode)
                FR_ARM: begin
                    if (st_q.arm == ARM_W'(ARM_N - 1)) begin
                        st_d.mode = FR_RUN;
                        st_d.pos  = '0;
                        st_d.fs   = 1'b1;
                    end else begin
                        st_d.arm = st_q.arm + ARM_W'(1);
                    end
                end
                default: begin
                    st_d.pos = pos_nx;
                    st_d.fs  = CMP_W'(pos_nx) <= CMP_W'(st_q.wid);
                end
            endcase
        end

        if (!gen_en) begin
            st_d.per = frm_per;
            st_d.wid = frm_wid;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: FR_ARM, arm: '0, per: '0, wid: '0, pos: '0, fs: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign fsync = st_q.fs;

endmodule

// File: rtl/srg_gate.sv
module srg_gate
    import srg_pkg::*;
(
    input  logic     bclk,
    input  logic     fsync,
    input  logic     gen_act,
    input  logic     rx_en,
    input  logic     tx_en,
    input  logic     rx_fs_pol,
    input  logic     tx_fs_pol,
    output pin_out_t pins
);

    always_comb begin
        pins.rx_sck = bclk & gen_act;
        pins.tx_sck = bclk & gen_act;
        pins.rx_fs  = rx_fs_pol ^ (fsync & rx_en);
        pins.tx_fs  = tx_fs_pol ^ (fsync & tx_en);
        pins.tx_oe  = tx_en;
    end

endmodule

// File: rtl/srg_core.sv
module srg_core
    import srg_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int PER_W = 12,
    parameter int WID_W = 8,
    parameter int ARM_N = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             fs_en,
    input  logic             rx_en,
    input  logic             tx_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [PER_W-1:0] frm_per,
    input  logic [WID_W-1:0] frm_wid,
    input  logic             rx_fs_pol,
    input  logic             tx_fs_pol,
    output logic             bclk,
    output logic             fsync,
    output logic             rx_sck,
    output logic             tx_sck,
    output logic             rx_fs,
    output logic             tx_fs,
    output logic             tx_data_oe
);

    logic     tick;
    logic     gen_act;
    pin_out_t pins;

    srg_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_en  (gen_en),
        .div_val (div_val),
        .bclk    (bclk),
        .tick    (tick),
        .gen_act (gen_act)
    );

    srg_frame #(.PER_W(PER_W), .WID_W(WID_W), .ARM_N(ARM_N)) u_frm (
        .clk     (clk),
        .rst_n   (rst_n),
        .gen_en  (gen_en),
        .gen_act (gen_act),
        .fs_en   (fs_en),
        .tick    (tick),
        .frm_per (frm_per),
        .frm_wid (frm_wid),
        .fsync   (fsync)
    );

    srg_gate u_gate (
        .bclk      (bclk),
        .fsync     (fsync),
        .gen_act   (gen_act),
        .rx_en     (rx_en),
        .tx_en     (tx_en),
        .rx_fs_pol (rx_fs_pol),
        .tx_fs_pol (tx_fs_pol),
        .pins      (pins)
    );

    assign rx_sck     = pins.rx_sck;
    assign tx_sck     = pins.tx_sck;
    assign rx_fs      = pins.rx_fs;
    assign tx_fs      = pins.tx_fs;
    assign tx_data_oe = pins.tx_oe;

endmodule

// File: rtl/srg_core_chk.sv
module srg_core_chk (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic fs_en,
    input logic rx_en,
    input logic tx_en,
    input logic rx_fs_pol,
    input logic tx_fs_pol,
    input logic bclk,
    input logic fsync,
    input logic rx_sck,
    input logic tx_sck,
    input logic rx_fs,
    input logic tx_fs,
    input logic tx_data_oe
);

    logic seen_gen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_gen_q <= 1'b0;
        end else if (gen_en) begin
            seen_gen_q <= 1'b1;
        end
    end

    AST_BOOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_gen_q |-> (!fsync && !rx_sck && !tx_sck)); // R1

    AST_GEN_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_gen_q && !$past(gen_en) && !$past(gen_en, 2)) |-> (!bclk && !fsync)); // R2

    AST_FS_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync) |-> bclk); // R5

    AST_FRST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(fs_en) |-> !fsync); // R7

    AST_RX_FS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |-> (rx_fs == rx_fs_pol)); // R8

    AST_TX_FS_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (tx_fs == tx_fs_pol)); // R8

    AST_TX_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> !tx_data_oe); // R9

    AST_SCK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen_en) |-> (!rx_sck && !tx_sck)); // R10

    AST_SCK_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sck || tx_sck) |-> bclk); // R10

    AST_DIR_INDEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && tx_en && fsync) |-> (tx_fs != tx_fs_pol)); // R11

endmodule

bind srg_core srg_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .fs_en      (fs_en),
    .rx_en      (rx_en),
    .tx_en      (tx_en),
    .rx_fs_pol  (rx_fs_pol),
    .tx_fs_pol  (tx_fs_pol),
    .bclk       (bclk),
    .fsync      (fsync),
    .rx_sck     (rx_sck),
    .tx_sck     (tx_sck),
    .rx_fs      (rx_fs),
    .tx_fs      (tx_fs),
    .tx_data_oe (tx_data_oe)
);

// File: tb/srg_core_test.sv
module srg_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0, fs_en = 1'b0, rx_en = 1'b0, tx_en = 1'b0;
    logic [7:0]  div_val = 8'd5;
    logic [11:0] frm_per = 12'd0;
    logic [7:0]  frm_wid = 8'd0;
    logic        rx_fs_pol = 1'b0, tx_fs_pol = 1'b0;
    logic        bclk, fsync, rx_sck, tx_sck, rx_fs, tx_fs, tx_data_oe;

    srg_core uut (
        .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .fs_en(fs_en),
        .rx_en(rx_en), .tx_en(tx_en), .div_val(div_val), .frm_per(frm_per),
        .frm_wid(frm_wid), .rx_fs_pol(rx_fs_pol), .tx_fs_pol(tx_fs_pol),
        .bclk(bclk), .fsync(fsync), .rx_sck(rx_sck), .tx_sck(tx_sck),
        .rx_fs(rx_fs), .tx_fs(tx_fs), .tx_data_oe(tx_data_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int m_boot = 1, m_run = 1, m_div = 0, m_cnt = 0, m_per = 0, m_wid = 0;
    int m_arm = 0, m_pos = 0, m_fs = 0, m_framing = 0;
    string cur_req = "R1";

    function automatic int m_lim();
        if (m_boot != 0) return 1;
        return (m_div == 0) ? 1 : m_div;
    endfunction

    always @(posedge clk) begin
        int lim, tck, act, nb, nr;
        if (!rst_n) begin
            m_boot = 1; m_run = 1; m_div = 0; m_cnt = 0; m_per = 0; m_wid = 0;
            m_arm = 0; m_pos = 0; m_fs = 0; m_framing = 0;
        end else begin
            lim = m_lim();
            tck = (m_run != 0 && m_cnt == lim) ? 1 : 0;
            act = (m_run != 0 && m_boot == 0) ? 1 : 0;
            if (!(fs_en && act != 0)) begin
                m_arm = 0; m_pos = 0; m_fs = 0; m_framing = 0;
            end else if (tck != 0) begin
                if (m_framing == 0) begin
                    if (m_arm == 7) begin m_framing = 1; m_pos = 0; m_fs = 1; end
                    else m_arm++;
                end else begin
                    m_pos = (m_pos == m_per) ? 0 : m_pos + 1;
                    m_fs  = (m_pos <= m_wid) ? 1 : 0;
                end
            end
            if (!gen_en) begin
                m_div = div_val; m_per = frm_per; m_wid = frm_wid;
            end
            nb = (m_boot != 0 && !gen_en) ? 1 : 0;
            nr = (gen_en || nb != 0) ? 1 : 0;
            m_cnt = (nr != 0 && m_run != 0 && tck == 0) ? m_cnt + 1 : 0;
            m_boot = nb; m_run = nr;
        end
    end

    int mc_checks = 0, mc_fails = 0;

    always @(negedge clk) begin
        int lim, half, e_bclk, act, e_sck;
        lim    = m_lim();
        half   = (lim + 1) / 2;
        e_bclk = (m_run != 0 && m_cnt < half) ? 1 : 0;
        act    = (m_run != 0 && m_boot == 0) ? 1 : 0;
        e_sck  = e_bclk & act;
        mc_checks += 7;
        if (int'(bclk) != e_bclk) begin mc_fails++;
            $display("FAIL %s bclk act=%0d exp=%0d t=%0t", cur_req, bclk, e_bclk, $time); end
        if (int'(fsync) != m_fs) begin mc_fails++;
            $display("FAIL %s fsync act=%0d exp=%0d t=%0t", cur_req, fsync, m_fs, $time); end
        if (int'(rx_sck) != e_sck) begin mc_fails++;
            $display("FAIL %s rx_sck act=%0d exp=%0d t=%0t", cur_req, rx_sck, e_sck, $time); end
        if (int'(tx_sck) != e_sck) begin mc_fails++;
            $display("FAIL %s tx_sck act=%0d exp=%0d t=%0t", cur_req, tx_sck, e_sck, $time); end
        if (rx_fs != (rx_fs_pol ^ (m_fs[0] & rx_en))) begin mc_fails++;
            $display("FAIL %s rx_fs act=%0d exp=%0d t=%0t", cur_req, rx_fs,
                     rx_fs_pol ^ (m_fs[0] & rx_en), $time); end
        if (tx_fs != (tx_fs_pol ^ (m_fs[0] & tx_en))) begin mc_fails++;
            $display("FAIL %s tx_fs act=%0d exp=%0d t=%0t", cur_req, tx_fs,
                     tx_fs_pol ^ (m_fs[0] & tx_en), $time); end
        if (tx_data_oe != tx_en) begin mc_fails++;
            $display("FAIL R9 tx_data_oe act=%0d exp=%0d t=%0t", tx_data_oe, tx_en, $time); end
    end

    // ---------------- directed checks ----------------
    int ec_checks = 0, ec_fails = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            $display("FAIL watchdog expired act=%0d exp<=%0d", cyc, WD_LIMIT);
            $display("%0d/%0d checks passed",
                     mc_checks + ec_checks - mc_fails - ec_fails,
                     mc_checks + ec_checks + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        ec_checks++;
        if (act != exp) begin
            ec_fails++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // measure period and high time (in core cycles) of bclk (sel=0) or fsync (sel=1)
    task automatic measure(input bit sel, output int per, output int hi);
        bit prev, cur;
        @(negedge clk);
        prev = sel ? fsync : bclk;
        while (1) begin
            @(negedge clk);
            cur = sel ? fsync : bclk;
            if (!prev && cur) break;
            prev = cur;
        end
        per = 1; hi = 1; prev = 1'b1;
        while (1) begin
            @(negedge clk);
            cur = sel ? fsync : bclk;
            if (!prev && cur) break;
            if (cur) hi++;
            per++;
            prev = cur;
        end
    endtask

    initial begin
        int p, h, n, pulses;
        bit last;

        // reset state, R1
        @(negedge clk);
        chk("R1", "bclk in reset", bclk, 1);
        chk("R1", "fsync in reset", fsync, 0);
        chk("R1", "rx_sck in reset", rx_sck, 0);
        chk("R9", "tx_data_oe in reset", tx_data_oe, 0);
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: divide-by-two boot clock, divider input ignored
        cur_req = "R1";
        cycles(6);
        measure(1'b0, p, h);
        chk("R1", "boot period", p, 2);
        chk("R1", "boot high", h, 1);

        // R3: programmed divider 4 -> period 5, high 2
        cycles(1);
        div_val = 8'd4;
        cur_req = "R3";
        cycles(1); gen_en = 1'b1;
        cycles(20);
        measure(1'b0, p, h);
        chk("R3", "period div4", p, 5);
        chk("R3", "high div4", h, 2);

        // R2 / R10: generator off holds clock low
        cycles(1);
        cur_req = "R2";
        gen_en = 1'b0;
        cycles(3);
        @(negedge clk);
        chk("R2", "bclk with gen off", bclk, 0);
        chk("R10", "rx_sck with gen off", rx_sck, 0);

        // R3: zero divider clamps to period 2
        cycles(1);
        div_val = 8'd0;
        cur_req = "R3";
        cycles(1); gen_en = 1'b1;
        cycles(4);
        measure(1'b0, p, h);
        chk("R3", "period div0", p, 2);

        // R4: change while running is ignored
        cycles(1); gen_en = 1'b0; div_val = 8'd2;
        cycles(2); gen_en = 1'b1;
        cycles(2);
        cur_req = "R4";
        div_val = 8'd6; frm_per = 12'd9;
        cycles(10);
        measure(1'b0, p, h);
        chk("R4", "period after live write", p, 3);

        // R5: both enables raised together, div 3 -> P = 4
        cycles(1);
        gen_en = 1'b0; div_val = 8'd3; frm_per = 12'd5; frm_wid = 8'd1;
        rx_en = 1'b1; tx_en = 1'b1;
        cur_req = "R5";
        cycles(3);
        gen_en = 1'b1; fs_en = 1'b1;
        n = 0;
        while (1) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (fsync) break;
        end
        chk("R5", "edges to first fsync", n, 1 + 8 * 4);
        chk("R5", "bclk at fsync start", bclk, 1);

        // R6: frame every 6 periods (24 cycles), 2 periods wide (8 cycles)
        cur_req = "R6";
        measure(1'b1, p, h);
        chk("R6", "frame period", p, 24);
        chk("R6", "frame high", h, 8);

        // R8: active-low polarity on both pins
        cycles(1);
        cur_req = "R8";
        rx_fs_pol = 1'b1; tx_fs_pol = 1'b1;
        cycles(30);

        // R11: receive in reset, transmit keeps framing
        cur_req = "R11";
        rx_en = 1'b0;
        pulses = 0; last = tx_fs;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (tx_fs !== rx_fs_pol) begin end
            if (last && !tx_fs) pulses++;
            last = tx_fs;
        end
        chk("R11", "tx_fs active pulses while rx held", (pulses > 0) ? 1 : 0, 1);
        chk("R8", "rx_fs parked", rx_fs, 1);

        // R9: transmitter off
        cycles(1);
        cur_req = "R9";
        tx_en = 1'b0;
        cycles(1);
        @(negedge clk);
        chk("R9", "tx_data_oe off", tx_data_oe, 0);
        chk("R8", "tx_fs parked", tx_fs, 1);

        // R7: frame enable off and back on
        cycles(1);
        cur_req = "R7";
        rx_en = 1'b1; tx_en = 1'b1; rx_fs_pol = 1'b0; tx_fs_pol = 1'b0;
        fs_en = 1'b0;
        cycles(1);
        @(negedge clk);
        chk("R7", "fsync after fs_en low", fsync, 0);
        cycles(1);
        fs_en = 1'b1;
        cycles(28);
        @(negedge clk);
        chk("R7", "fsync still low during restart wait", fsync, 0);
        cycles(60);

        // R6: width >= period gives continuous sync
        cur_req = "R6";
        gen_en = 1'b0; frm_per = 12'd2; frm_wid = 8'd4; div_val = 8'd1;
        cycles(3);
        gen_en = 1'b1;
        cycles(40);
        n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fsync) n++;
        end
        chk("R6", "continuous sync cycles", n, 20);

        // R10: clock outputs follow bclk while running
        cur_req = "R10";
        @(negedge clk);
        chk("R10", "rx_sck equals bclk", rx_sck, bclk);
        chk("R10", "tx_sck equals bclk", tx_sck, bclk);
        cycles(5);

        $display("%0d/%0d checks passed",
                 mc_checks + ec_checks - mc_fails - ec_fails,
                 mc_checks + ec_checks);
        $finish;
    end

endmodule